// File: doc/BRIEF.md
# Narrow-Bus Register Access Adapter

This adapter sits between a host-side master that issues 32-bit register reads and writes and a peripheral register file. That register file may be reached over a 32-bit data bus or over a 16-bit data bus. A two-bit static mode input picks one of three bus styles: plain, wide or narrow. The adapter turns each logical register offset into a peripheral byte address for that style. In narrow style it also breaks one 32-bit access into one or two 16-bit beats and builds the 32-bit read result from them.

Only some registers are handled as 32-bit pairs in narrow style, and the list differs by direction. Four response registers get a second beat when read. Five control registers get a second beat when written: two status registers, their two mask registers and the argument register. Every other access is one 16-bit beat. Both lists are parameters.

The sequencer has four states:
- ST_IDLE: waits for a request.
- ST_BEAT_LO: issues the low or only beat.
- ST_BEAT_HI: issues the upper-half beat.
- ST_RESP: acknowledges the host for one cycle.

The transitions are:
- ACCEPT: ST_IDLE to ST_BEAT_LO, when up_valid is high.
- LO_TO_HI: ST_BEAT_LO to ST_BEAT_HI, when the low beat is taken and the access is paired.
- LO_TO_RESP: ST_BEAT_LO to ST_RESP, when the low beat is taken and the access is not paired.
- HI_TO_RESP: ST_BEAT_HI to ST_RESP, when the high beat is taken.
- RELEASE: ST_RESP to ST_IDLE, always.

Top module: `narrow_reg_bridge`

## Requirements
- R1: With bus_mode 0 (plain), the adapter issues one 32-bit beat with dn_half low. The beat has dn_addr equal to the offset, and write data passes unchanged.
- R2: With bus_mode 2 (wide), the adapter issues one 32-bit beat with dn_half low. The beat has dn_addr equal to the offset shifted left by one. Read data is returned unchanged.
- R3: With bus_mode 1 (narrow), the first beat has dn_half high and goes to the offset shifted right by one. Each narrow write beat carries its 16 data bits in dn_wdata[15:0], with dn_wdata[31:16] zero.
- R4: A narrow read of a response register (offsets 0x018, 0x020, 0x028, 0x030) issues a second beat at the translated address plus 2. The read returns {second beat bits 15..0, first beat bits 15..0}.
- R5: A narrow write to offsets 0x010, 0x038, 0x03C, 0x040 or 0x044 issues a second beat at the translated address plus 2. That beat carries up_wdata[31:16] in dn_wdata[15:0].
- R6: A narrow access to any other offset, or in the other direction, is a single beat. A read returns zero in bits 31..16, and a write discards up_wdata[31:16].
- R7: The low-half beat always comes before the high-half beat. up_ready is high for exactly one cycle, in the cycle after the final beat handshake, and never while dn_valid is high. No beat is issued without an accepted request. After reset, dn_valid and up_ready are low.
- R8: While dn_valid is high and dn_ready is low, dn_valid, dn_addr, dn_wdata and dn_write hold their values.
- R9: bus_mode is sampled only when a request is accepted. A change during an access does not alter that access.
- R10: bus_mode 3 behaves as plain mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_mode | input | 2 | Bus style: 0 plain, 1 narrow 16-bit, 2 wide, 3 plain |
| up_valid | input | 1 | Host request valid, held until up_ready |
| up_write | input | 1 | 1 = write, 0 = read |
| up_offset | input | AW (11) | Logical register offset |
| up_wdata | input | 32 | Host write data |
| up_ready | output | 1 | One-cycle completion acknowledge |
| up_rdata | output | 32 | Read result, valid while up_ready is high |
| dn_valid | output | 1 | Peripheral beat valid |
| dn_write | output | 1 | Peripheral beat direction |
| dn_half | output | 1 | 1 = 16-bit beat |
| dn_addr | output | AW+1 (12) | Peripheral byte address |
| dn_wdata | output | 32 | Peripheral write data |
| dn_ready | input | 1 | Peripheral accepts the beat |
| dn_rdata | input | 32 | Peripheral read data, valid with dn_ready |

## Verification
The first beat is due on dn_valid one cycle after the clock edge that sees up_valid. Each following beat or the acknowledge is due one cycle after the edge where dn_valid and dn_ready are both high, so a paired access with no stalls acknowledges three cycles after the request. The bench drives and samples on falling edges. It keeps a queue of expected beats per access and matches every beat handshake against the queue head. It checks hold behaviour on every stalled cycle, and checks read data and queue emptiness in the single cycle where up_ready is high. Stalls come from a pseudo-random ready pattern, and one access changes bus_mode while it is in flight.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

    localparam int DATA_W = 32;
    localparam int HALF_W = 16;

    typedef enum logic [1:0] {
        BM_PLAIN  = 2'd0,
        BM_NARROW = 2'd1,
        BM_WIDE   = 2'd2,
        BM_RSVD   = 2'd3
    } bus_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_BEAT_LO = 2'd1,
        ST_BEAT_HI = 2'd2,
        ST_RESP    = 2'd3
    } seq_state_e;

endpackage

// File: rtl/bridge_addr_map.sv
module bridge_addr_map
    import bridge_pkg::*;
#(
    parameter int AW   = 11,
    parameter int N_RD = 4,
    parameter int N_WR = 5,
    parameter logic [N_RD*AW-1:0] RD_PAIR_LIST = '0,
    parameter logic [N_WR*AW-1:0] WR_PAIR_LIST = '0
) (
    input  bus_mode_e       mode,
    input  logic [AW-1:0]   offset,
    input  logic            write,
    output logic [AW:0]     base_addr,
    output logic            narrow,
    output logic            want_hi
);

    logic [N_RD-1:0] rd_hit;
    logic [N_WR-1:0] wr_hit;

    for (genvar i = 0; i < N_RD; i++) begin : g_rd_match
        assign rd_hit[i] = (offset == RD_PAIR_LIST[i*AW +: AW]);
    end

    for (genvar j = 0; j < N_WR; j++) begin : g_wr_match
        assign wr_hit[j] = (offset == WR_PAIR_LIST[j*AW +: AW]);
    end

    always_comb begin
        narrow = 1'b0;
        case (mode)
            BM_NARROW: begin
                base_addr = {2'b00, offset[AW-1:1]};
                narrow    = 1'b1;
            end
            BM_WIDE:   base_addr = {offset, 1'b0};
            default:   base_addr = {1'b0, offset};
        endcase
    end

    assign want_hi = narrow && (write ? (|wr_hit) : (|rd_hit));

endmodule

// File: rtl/bridge_seq.sv
module bridge_seq
    import bridge_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic up_valid,
    input  logic want_hi,
    input  logic dn_ready,
    output logic accept,
    output logic dn_valid,
    output logic beat_hi,
    output logic cap_lo,
    output logic cap_hi,
    output logic up_ready
);

    seq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (up_valid) state_d = ST_BEAT_LO;
            ST_BEAT_LO: if (dn_ready) state_d = want_hi ? ST_BEAT_HI : ST_RESP;
            ST_BEAT_HI: if (dn_ready) state_d = ST_RESP;
            ST_RESP:    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        accept   = 1'b0;
        dn_valid = 1'b0;
        beat_hi  = 1'b0;
        cap_lo   = 1'b0;
        cap_hi   = 1'b0;
        up_ready = 1'b0;
        unique case (state_q)
            ST_IDLE:    accept = up_valid;
            ST_BEAT_LO: begin
                dn_valid = 1'b1;
                cap_lo   = dn_ready;
            end
            ST_BEAT_HI: begin
                dn_valid = 1'b1;
                beat_hi  = 1'b1;
                cap_hi   = dn_ready;
            end
            ST_RESP:    up_ready = 1'b1;
        endcase
    end

    assert_ack_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        up_ready |=> !up_ready);

    assert_ack_not_with_beat_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(up_ready && dn_valid));

    assert_no_gap_after_beat_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && dn_ready) |=> (dn_valid || up_ready));

endmodule

// File: rtl/bridge_rdata_asm.sv
module bridge_rdata_asm
    import bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              cap_lo,
    input  logic              cap_hi,
    input  logic              narrow,
    input  logic [DATA_W-1:0] beat_data,
    output logic [DATA_W-1:0] rdata
);

    logic [HALF_W-1:0] hi_q, lo_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (clear) begin
            hi_q <= '0;
            lo_q <= '0;
        end else begin
            if (cap_lo) begin
                lo_q <= beat_data[HALF_W-1:0];
                hi_q <= narrow ? '0 : beat_data[DATA_W-1:HALF_W];
            end
            if (cap_hi) hi_q <= beat_data[HALF_W-1:0];
        end
    end

    assign rdata = {hi_q, lo_q};

endmodule

// File: rtl/narrow_reg_bridge.sv
module narrow_reg_bridge
    import bridge_pkg::*;
#(
    parameter int AW   = 11,
    parameter int N_RD = 4,
    parameter int N_WR = 5,
    parameter logic [N_RD*AW-1:0] RD_PAIR_LIST =
        {AW'(12'h030), AW'(12'h028), AW'(12'h020), AW'(12'h018)},
    parameter logic [N_WR*AW-1:0] WR_PAIR_LIST =
        {AW'(12'h044), AW'(12'h040), AW'(12'h03C), AW'(12'h038), AW'(12'h010)}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_mode,
    input  logic              up_valid,
    input  logic              up_write,
    input  logic [AW-1:0]     up_offset,
    input  logic [DATA_W-1:0] up_wdata,
    output logic              up_ready,
    output logic [DATA_W-1:0] up_rdata,
    output logic              dn_valid,
    output logic              dn_write,
    output logic              dn_half,
    output logic [AW:0]       dn_addr,
    output logic [DATA_W-1:0] dn_wdata,
    input  logic              dn_ready,
    input  logic [DATA_W-1:0] dn_rdata
);

    localparam logic [AW:0] HI_STEP = (AW+1)'(2);

    bus_mode_e         req_mode;
    logic              req_wr;
    logic [AW-1:0]     req_ofs;
    logic [DATA_W-1:0] req_wd;

    logic        accept, beat_hi, cap_lo, cap_hi;
    logic        narrow, want_hi;
    logic [AW:0] base_addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_mode <= BM_PLAIN;
            req_wr   <= 1'b0;
            req_ofs  <= '0;
            req_wd   <= '0;
        end else if (accept) begin
            req_mode <= bus_mode_e'(bus_mode);
            req_wr   <= up_write;
            req_ofs  <= up_offset;
            req_wd   <= up_wdata;
        end
    end

    bridge_addr_map #(
        .AW(AW), .N_RD(N_RD), .N_WR(N_WR),
        .RD_PAIR_LIST(RD_PAIR_LIST), .WR_PAIR_LIST(WR_PAIR_LIST)
    ) u_map (
        .mode      (req_mode),
        .offset    (req_ofs),
        .write     (req_wr),
        .base_addr (base_addr),
        .narrow    (narrow),
        .want_hi   (want_hi)
    );

    bridge_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .up_valid (up_valid),
        .want_hi  (want_hi),
        .dn_ready (dn_ready),
        .accept   (accept),
        .dn_valid (dn_valid),
        .beat_hi  (beat_hi),
        .cap_lo   (cap_lo),
        .cap_hi   (cap_hi),
        .up_ready (up_ready)
    );

    bridge_rdata_asm u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept),
        .cap_lo    (cap_lo),
        .cap_hi    (cap_hi),
        .narrow    (narrow),
        .beat_data (dn_rdata),
        .rdata     (up_rdata)
    );

    assign dn_write = req_wr;
    assign dn_half  = narrow;
    assign dn_addr  = beat_hi ? base_addr + HI_STEP : base_addr;

    always_comb begin
        if (!narrow)      dn_wdata = req_wd;
        else if (beat_hi) dn_wdata = {{HALF_W{1'b0}}, req_wd[DATA_W-1:HALF_W]};
        else              dn_wdata = {{HALF_W{1'b0}}, req_wd[HALF_W-1:0]};
    end

    assert_beat_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && !dn_ready) |=>
            (dn_valid && $stable(dn_addr) && $stable(dn_wdata) && $stable(dn_write)));

    assert_narrow_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && dn_half) |-> (dn_wdata[DATA_W-1:HALF_W] == '0));

    assert_hi_beat_narrow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && dn_ready && dn_half && !up_ready) |=> (up_ready || dn_half));

endmodule

// File: tb/tb_narrow_reg_bridge.sv
module tb_narrow_reg_bridge;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_mode = 2'd0;
    logic        up_valid = 1'b0;
    logic        up_write = 1'b0;
    logic [10:0] up_offset = '0;
    logic [31:0] up_wdata = '0;
    logic        up_ready;
    logic [31:0] up_rdata;
    logic        dn_valid, dn_write, dn_half;
    logic [11:0] dn_addr;
    logic [31:0] dn_wdata;
    logic        dn_ready = 1'b0;
    logic [31:0] dn_rdata = '0;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;
    bit always_ready = 1'b1;
    logic [7:0] lfsr = 8'hA7;

    logic [11:0] qa[$];
    logic [31:0] qd[$];
    bit          qw[$];
    bit          qh[$];

    bit          prev_stall = 1'b0;
    logic [11:0] prev_addr;
    logic [31:0] prev_wd;
    bit          prev_wr;

    always #5 clk = ~clk;

    narrow_reg_bridge dut (
        .clk(clk), .rst_n(rst_n), .bus_mode(bus_mode),
        .up_valid(up_valid), .up_write(up_write), .up_offset(up_offset),
        .up_wdata(up_wdata), .up_ready(up_ready), .up_rdata(up_rdata),
        .dn_valid(dn_valid), .dn_write(dn_write), .dn_half(dn_half),
        .dn_addr(dn_addr), .dn_wdata(dn_wdata), .dn_ready(dn_ready),
        .dn_rdata(dn_rdata)
    );

    function automatic logic [31:0] resp_of(logic [11:0] a);
        return {a ^ 12'h5A3, 4'h9, ~a, 4'h6};
    endfunction

    function automatic bit in_rd_list(logic [10:0] o);
        return (o == 11'h018) || (o == 11'h020) || (o == 11'h028) || (o == 11'h030);
    endfunction

    function automatic bit in_wr_list(logic [10:0] o);
        return (o == 11'h010) || (o == 11'h038) || (o == 11'h03C) ||
               (o == 11'h040) || (o == 11'h044);
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", cycles, 150000);
            finish_run();
        end
    end

    // Peripheral responder and beat checker (R1..R8)
    always @(negedge clk) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        dn_ready = always_ready ? 1'b1 : (lfsr[0] | lfsr[1]);
        dn_rdata = resp_of(dn_addr);
        if (rst_n) begin
            if (prev_stall)
                check(dn_valid && dn_addr == prev_addr && dn_wdata == prev_wd &&
                      dn_write == prev_wr, "R8 hold", {20'h0, dn_addr}, {20'h0, prev_addr});
            prev_stall = dn_valid && !dn_ready;
            prev_addr  = dn_addr;
            prev_wd    = dn_wdata;
            prev_wr    = dn_write;
            if (dn_valid && dn_ready) begin
                if (qa.size() == 0) begin
                    check(1'b0, "R7 unexpected beat", {20'h0, dn_addr}, 32'h0);
                end else begin
                    check(dn_addr == qa[0], "R1-R6 beat addr", {20'h0, dn_addr}, {20'h0, qa[0]});
                    check(dn_write == qw[0] && dn_half == qh[0], "R1-R6 beat kind",
                          {30'h0, dn_write, dn_half}, {30'h0, qw[0], qh[0]});
                    if (qw[0])
                        check(dn_wdata == qd[0], "R1-R6 beat wdata", dn_wdata, qd[0]);
                    void'(qa.pop_front()); void'(qd.pop_front());
                    void'(qw.pop_front()); void'(qh.pop_front());
                end
            end
        end
    end

    task automatic do_access(input logic [1:0] m, input bit wr, input logic [10:0] ofs,
                             input logic [31:0] wd, input bit flip, input string req);
        logic [11:0] base;
        bit nar, paired;
        logic [31:0] exp_rd;
        int waitc;
        logic [31:0] b0, b1;
        nar = (m == 2'd1);
        case (m)
            2'd1:    base = {2'b00, ofs[10:1]};
            2'd2:    base = {ofs, 1'b0};
            default: base = {1'b0, ofs};
        endcase
        paired = nar && (wr ? in_wr_list(ofs) : in_rd_list(ofs));
        qa.push_back(base); qw.push_back(wr); qh.push_back(nar);
        qd.push_back(nar ? {16'h0, wd[15:0]} : wd);
        if (paired) begin
            qa.push_back(base + 12'd2); qw.push_back(wr); qh.push_back(1'b1);
            qd.push_back({16'h0, wd[31:16]});
        end
        b0 = resp_of(base);
        b1 = resp_of(base + 12'd2);
        exp_rd = !nar ? b0 : {paired ? b1[15:0] : 16'h0, b0[15:0]};

        @(negedge clk);
        bus_mode = m; up_valid = 1'b1; up_write = wr; up_offset = ofs; up_wdata = wd;
        waitc = 0;
        do begin
            @(negedge clk);
            waitc++;
            if (flip && waitc == 1) bus_mode = ~m;
        end while (!up_ready && waitc < 300);
        check(up_ready, {req, " ack"}, {31'h0, up_ready}, 32'h1);
        check(qa.size() == 0, {req, " R7 all beats before ack"}, qa.size(), 32'h0);
        if (!wr) check(up_rdata == exp_rd, {req, " rdata"}, up_rdata, exp_rd);
        up_valid = 1'b0;
        @(negedge clk);
        check(!up_ready, "R7 ack one cycle", {31'h0, up_ready}, 32'h0);
        qa.delete(); qd.delete(); qw.delete(); qh.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!dn_valid && !up_ready, "R7 reset state", {30'h0, dn_valid, up_ready}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!dn_valid && !up_ready, "R7 idle after reset", {30'h0, dn_valid, up_ready}, 32'h0);

        for (int pass = 0; pass < 2; pass++) begin
            always_ready = (pass == 0);
            do_access(2'd0, 1'b1, 11'h123, 32'hDEADBEEF, 1'b0, "R1 plain write");
            do_access(2'd0, 1'b0, 11'h018, 32'h0,        1'b0, "R1 plain read");
            do_access(2'd2, 1'b0, 11'h3FF, 32'h0,        1'b0, "R2 wide read");
            do_access(2'd2, 1'b1, 11'h044, 32'h13579BDF, 1'b0, "R2 wide write");
            do_access(2'd1, 1'b0, 11'h018, 32'h0,        1'b0, "R4 narrow paired read");
            do_access(2'd1, 1'b0, 11'h030, 32'h0,        1'b0, "R4 narrow paired read last");
            do_access(2'd1, 1'b1, 11'h010, 32'hCAFEF00D, 1'b0, "R5 narrow paired write arg");
            do_access(2'd1, 1'b1, 11'h044, 32'h89ABCDEF, 1'b0, "R5 narrow paired write mask");
            do_access(2'd1, 1'b1, 11'h038, 32'h0F0F1234, 1'b0, "R5 narrow paired write status");
            do_access(2'd1, 1'b0, 11'h010, 32'h0,        1'b0, "R6 narrow read unpaired");
            do_access(2'd1, 1'b1, 11'h020, 32'hFFFF5555, 1'b0, "R6 narrow write unpaired");
            do_access(2'd1, 1'b1, 11'h066, 32'hA5A5A5A5, 1'b0, "R3 narrow write single");
            do_access(2'd1, 1'b0, 11'h101, 32'h0,        1'b0, "R3 narrow read odd");
            do_access(2'd3, 1'b0, 11'h055, 32'h0,        1'b0, "R10 reserved mode read");
            do_access(2'd3, 1'b1, 11'h010, 32'h11223344, 1'b0, "R10 reserved mode write");
            do_access(2'd1, 1'b0, 11'h028, 32'h0,        1'b1, "R9 mode flip narrow");
            do_access(2'd2, 1'b1, 11'h040, 32'h55AA55AA, 1'b1, "R9 mode flip wide");
            do_access(2'd0, 1'b0, 11'h020, 32'h0,        1'b1, "R9 mode flip plain");
        end
        always_ready = 1'b0;
        for (int k = 0; k < 40; k++) begin
            logic [10:0] o;
            o = (k % 3 == 0) ? 11'h018 + 11'(8 * (k % 4)) : 11'(k * 37);
            do_access(2'(k % 3), 1'(k % 2), o, 32'h01020304 * k, 1'(k % 5 == 0), "R7 mixed");
        end
        finish_run();
    end

endmodule